// File: doc/BRIEF.md
# Context-Sequencing State Transition Controller

This block is a small table-programmed finite-state machine that steers an array of processing elements from one datapath configuration to the next. Its current state is the context pointer broadcast to every element, which uses it to index a local instruction store, so each state names a whole datapath plane. The array reports up to eight condition flags, and every state's table entry chooses one flag and two successor states. This is how if / else-if / else control maps onto the sequencer.

The controller runs apart from the array: it only supplies the pointer and consumes the flags. Software or a loader fills the transition table while the controller is not running. A start pulse then launches sequencing from state 0. The controller stops when it meets an entry marked as terminal, raises done and holds the final pointer until the next start.

Top module: `ctx_seq_ctrl`

## Requirements
- R1: After reset `ctx_ptr` is 0, `done` is 0 and every table entry is all-zero. An all-zero entry tests flag 0, has no halt mark and leads to state 0 on either outcome.
- R2: While the controller is idle (after reset and before the first start), `ctx_ptr` stays 0 and `done` stays 0 whatever the flags do.
- R3: A start seen while the controller is not running puts it into the running mode on the next cycle, with `ctx_ptr` = 0 and `done` = 0. A start seen while it is running has no effect.
- R4: Table entry encoding for `wr_data`: bit 11 is the halt mark, bits 10:7 are the next state if the tested flag is 1, bits 6:3 are the next state if it is 0, and bits 2:0 select the tested flag. While running, if the entry at `ctx_ptr` has no halt mark, `ctx_ptr` on the next cycle is the flag-1 successor when the selected flag is 1 and the flag-0 successor otherwise.
- R5: While running, an entry at `ctx_ptr` with the halt mark set makes `done` 1 on the next cycle. `ctx_ptr` keeps that state, and both hold until a start arrives.
- R6: A write (`wr_en` = 1) while the controller is not running stores `wr_data` at `wr_addr` on the clock edge. A write while running leaves the table unchanged.
- R7: When a write and a start arrive in the same cycle while not running, the write is stored, and the first evaluation after the start uses the new entry.
- R8: The 3-bit flag select reaches every one of the eight flag inputs: select value k tests `flags[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin sequencing from state 0 |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table entry written |
| wr_data | input | 12 | Entry contents (encoding in R4) |
| flags | input | 8 | Condition flags from the array |
| ctx_ptr | output | 4 | Context pointer to the array |
| done | output | 1 | Sequence reached a halting entry |

## Verification
Two things can fall in the same cycle: a table write and a start. The bench provokes this after reset by writing a halting entry at state 0 together with start, and then expects done two cycles later (R7). It also issues writes and starts at random while the controller is running, and it judges these by comparing pointer and done against a bench model that discards both. A directed case writes a halt mark into a self-looping running state and requires done to stay low.

// File: rtl/ctx_seq_pkg.sv
// Package: shared sizes and the transition-table entry layout.
// Assumes the state count and flag count are powers of two.
package ctx_seq_pkg;
    localparam int CTX_NUM  = 16;
    localparam int FLAG_NUM = 8;
    localparam int ST_W     = $clog2(CTX_NUM);
    localparam int SEL_W    = $clog2(FLAG_NUM);
    localparam int ENTRY_W  = 1 + 2 * ST_W + SEL_W;

    // Packed MSB first: halt, flag-true successor, flag-false successor, select
    typedef struct packed {
        logic             halt;
        logic [ST_W-1:0]  nxt_t;
        logic [ST_W-1:0]  nxt_f;
        logic [SEL_W-1:0] sel;
    } entry_t;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RUN  = 2'd1,
        M_HALT = 2'd2
    } mode_t;
endpackage

// File: rtl/ctx_trans_table.sv
// Transition table: one register per state, written through a gated strobe,
// read combinationally at the current state. Assumes the caller gates wr_en.
module ctx_trans_table
    import ctx_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_addr,
    input  entry_t          wr_data,
    input  logic [ST_W-1:0] rd_addr,
    output entry_t          rd_entry
);
    entry_t tbl_q [CTX_NUM];

    for (genvar i = 0; i < CTX_NUM; i++) begin : g_ent
        // Clear on reset, load when this slot is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_q[i] <= '0;
            else if (wr_en && (wr_addr == ST_W'(i)))
                tbl_q[i] <= wr_data;
        end
    end

    // Read port for the entry of the active state
    always_comb rd_entry = tbl_q[rd_addr];
endmodule

// File: rtl/ctx_cond_eval.sv
// Condition evaluation: picks the flag named by the entry and chooses the
// successor state. Purely combinational.
module ctx_cond_eval
    import ctx_seq_pkg::*;
(
    input  entry_t              entry,
    input  logic [FLAG_NUM-1:0] flags,
    output logic [ST_W-1:0]     nxt,
    output logic                halt
);
    logic flag_hit;

    // Select the tested flag and resolve the branch
    always_comb begin
        flag_hit = flags[entry.sel];
        nxt      = flag_hit ? entry.nxt_t : entry.nxt_f;
        halt     = entry.halt;
    end
endmodule

// File: rtl/ctx_seq_ctrl.sv
// Context sequencer top: holds the mode and the context pointer, steps through
// the transition table while running. Assumes synchronous active-low reset
// and that flags are valid in the cycle the current entry is evaluated.
module ctx_seq_ctrl
    import ctx_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                wr_en,
    input  logic [ST_W-1:0]     wr_addr,
    input  logic [ENTRY_W-1:0]  wr_data,
    input  logic [FLAG_NUM-1:0] flags,
    output logic [ST_W-1:0]     ctx_ptr,
    output logic                done
);
    mode_t           mode_q;
    logic [ST_W-1:0] ptr_q;
    logic            done_q;
    logic            tbl_we;
    entry_t          cur_entry;
    logic [ST_W-1:0] eval_nxt;
    logic            eval_halt;

    // Table writes pass only when not running
    always_comb tbl_we = wr_en && (mode_q != M_RUN);

    ctx_trans_table u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (wr_addr),
        .wr_data  (entry_t'(wr_data)),
        .rd_addr  (ptr_q),
        .rd_entry (cur_entry)
    );

    ctx_cond_eval u_eval (
        .entry (cur_entry),
        .flags (flags),
        .nxt   (eval_nxt),
        .halt  (eval_halt)
    );

    // Mode, pointer and done sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IDLE;
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (mode_q)
                M_RUN: begin
                    if (eval_halt) begin
                        mode_q <= M_HALT;
                        done_q <= 1'b1;
                    end else begin
                        ptr_q <= eval_nxt;
                    end
                end
                default: begin
                    if (start) begin
                        mode_q <= M_RUN;
                        ptr_q  <= '0;
                        done_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Drive outputs from state
    always_comb begin
        ctx_ptr = ptr_q;
        done    = done_q;
    end
endmodule

// File: rtl/ctx_seq_ctrl_chk.sv
// Checker for ctx_seq_ctrl: temporal properties on the mode and outputs.
// Assumes it is bound to the top with the mode decoded to flags.
module ctx_seq_ctrl_chk
    import ctx_seq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            running,
    input logic            idle,
    input logic [ST_W-1:0] ctx_ptr,
    input logic            done
);
    a_r2_idle_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (ctx_ptr == '0 && !done));

    a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start) |=> (running && ctx_ptr == '0 && !done));

    a_r3_no_done_running: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !done);

    a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(ctx_ptr)));

    a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(running));
endmodule

bind ctx_seq_ctrl ctx_seq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .running (mode_q == M_RUN),
    .idle    (mode_q == M_IDLE),
    .ctx_ptr (ctx_ptr),
    .done    (done)
);

// File: tb/ctx_seq_ctrl_test.sv
module ctx_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [7:0] flags = '0;
    logic [3:0] ctx_ptr;
    logic       done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Bench model: 0 idle, 1 running, 2 halted
    logic [11:0] m_tbl [16];
    int          m_mode;
    logic [3:0]  m_ptr;
    logic        m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .flags(flags),
        .ctx_ptr(ctx_ptr), .done(done)
    );

    function automatic logic [11:0] mk(bit h, int t, int f, int s);
        return {h, 4'(t), 4'(f), 3'(s)};
    endfunction

    task automatic check(string tag, logic [3:0] ep, logic ed);
        n_chk++;
        if (ctx_ptr !== ep || done !== ed) begin
            n_fail++;
            $display("FAIL %s: ptr=%0d done=%0b expected ptr=%0d done=%0b",
                     tag, ctx_ptr, done, ep, ed);
        end
    endtask

    task automatic model_step(bit s, bit we, logic [3:0] a, logic [11:0] d,
                              logic [7:0] fl);
        logic [11:0] e;
        e = m_tbl[m_ptr];
        if (m_mode == 1) begin
            if (e[11]) begin m_mode = 2; m_done = 1'b1; end
            else m_ptr = fl[e[2:0]] ? e[10:7] : e[6:3];
        end else begin
            if (we) m_tbl[a] = d;
            if (s) begin m_mode = 1; m_ptr = 0; m_done = 1'b0; end
        end
    endtask

    // One cycle: drive at negedge, model at posedge, check at next negedge
    task automatic step(bit s, bit we, logic [3:0] a, logic [11:0] d,
                        logic [7:0] fl, string tag);
        string t;
        start = s; wr_en = we; wr_addr = a; wr_data = d; flags = fl;
        if (tag != "") t = tag;
        else t = (m_mode == 0) ? "R2" : (m_mode == 1) ? "R4" : "R5";
        @(posedge clk);
        model_step(s, we, a, d, fl);
        @(negedge clk);
        check(t, m_ptr, m_done);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 0; wr_en = 0; flags = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) m_tbl[i] = '0;
        m_mode = 0; m_ptr = 0; m_done = 0;
        check("R1", 4'd0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // R2: idle ignores flags
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'(i * 37 + 1), "R2");
        // R1: all-zero table keeps state 0 and never halts
        step(1, 0, 0, 0, 8'hFF, "R1");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'hFF, "R1");
        // R6: write while running ignored (halt mark must not appear)
        step(0, 1, 0, mk(1, 0, 0, 0), 8'h00, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'h00, "R6");
        // R3: start while running ignored
        step(1, 0, 0, 0, 8'h00, "R3");

        // R7: write and start in the same cycle
        do_reset();
        step(1, 1, 0, mk(1, 0, 0, 0), 8'h00, "R7");
        step(0, 0, 0, 0, 8'h00, "R7");
        step(0, 0, 0, 0, 8'h00, "R5");

        // R8: each select value tests its own flag; successors 1 (true) / 2 (false)
        step(0, 1, 1, mk(1, 0, 0, 0), 0, "R6");
        step(0, 1, 2, mk(1, 0, 0, 0), 0, "R6");
        for (int k = 0; k < 8; k++) begin
            step(0, 1, 0, mk(0, 1, 2, k), 0, "R6");
            step(1, 0, 0, 0, 0, "R3");
            step(0, 0, 0, 0, 8'(1 << k), "R8");
            step(0, 0, 0, 0, 8'(~(1 << k)), "R5");
            step(1, 0, 0, 0, 0, "R3");
            step(0, 0, 0, 0, 8'(~(1 << k)), "R8");
            step(0, 0, 0, 0, 0, "R5");
        end

        // Random mix
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            bit s, we;
            logic [11:0] d;
            d = 12'($urandom);
            if (($urandom % 6) != 0) d[11] = 1'b0;
            we = ($urandom % 3) == 0;
            s  = ($urandom % 5) == 0;
            step(s, we, 4'($urandom), d, 8'($urandom), "");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: ran past %0d cycles, expected completion", MAX_CYC);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule